// File: doc/BRIEF.md
# Layer-2 Table Port Flush Engine

This block removes entries from a small on-chip layer-2 forwarding table under host control. Host software programs a selection value and a matching mode over a simple address/data register bus. It then sets one or more per-port start bits and polls the matching busy bits until they drop. The engine walks the whole entry array, one slot per clock, and invalidates every unicast entry that belongs to the port being flushed and passes the selected filter.

The filter can be the port alone, the port together with a VLAN ID, or the port together with a filter ID. A type bit decides whether static entries are protected or removed along with dynamic ones. A separate whole-table command invalidates every slot regardless of kind, and reads back as set until it has finished. The forwarding-side write port and a read-back of each slot's valid bit stand in for the lookup datapath that would normally fill the table.

Top module: `l2_flush_engine`

## Requirements
- R1: After reset every busy bit, the whole-table bit, the selection register and the configuration register read zero, and every table slot is invalid.
- R2: Writing address 0x0 with bit p (p in 0..7) set starts a flush of port p; in the cycle after the write, bit 8+p of address 0x0 reads 1, and bits 7:0 of address 0x0 always read 0.
- R3: Writing address 0x1 with bit k (k in 0..2) set starts a flush of port 8+k; bit 3+k of address 0x1 then reads 1 until that flush ends, and bits 2:0 always read 0.
- R4: With mode 0 (bits 1:0 of address 0x3), a port flush invalidates every valid unicast entry whose port equals the flushed port and leaves multicast entries and entries of other ports intact.
- R5: With mode 1, only entries whose VLAN ID equals bits 11:0 of address 0x2 are removed; address 0x2 reads back as written.
- R6: With mode 2, only entries whose filter ID equals bits 15:12 of address 0x2 are removed.
- R7: Mode 3 behaves as mode 0.
- R8: With bit 2 of address 0x3 at 0, static entries survive a port flush; with it at 1, static entries of the port are removed too.
- R9: Ports started in the same write are flushed one after another in ascending port order, and each busy bit drops when its own scan ends, so a lower port's busy bit clears DEPTH+1 cycles before the next one.
- R10: Writing 1 to bit 0 of address 0x4 invalidates every slot, static and multicast included; the bit reads 1 until the walk ends and then clears by itself; a pending whole-table flush is started before any pending port flush.
- R11: With the engine idle, a busy bit clears exactly DEPTH+1 cycles after its start write, and writing 0 to a start bit starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| tbl_we | input | 1 | Table slot write strobe |
| tbl_widx | input | IDX_W | Slot index for a table write |
| tbl_wvalid | input | 1 | Written entry valid |
| tbl_wmcast | input | 1 | Written entry is multicast |
| tbl_wstatic | input | 1 | Written entry is static |
| tbl_wport | input | 4 | Written entry port number |
| tbl_wvid | input | 12 | Written entry VLAN ID |
| tbl_wfid | input | 4 | Written entry filter ID |
| tbl_ridx | input | IDX_W | Slot index for valid read-back |
| tbl_rvalid | output | 1 | Valid bit of slot tbl_ridx |

## Verification
The hardest situation to reach is a whole-table request and a port request waiting together while the engine is busy. That is the only case where the start order between the two kinds of flush becomes visible. The stimulus first starts a port flush. While that scan runs, it sets another port's start bit and the whole-table bit. It then checks that the whole-table bit clears while the second port is still busy. Ascending port order is shown by starting two ports in one write and sampling the busy field at the cycle between their scan ends.

// File: rtl/l2fl_pkg.sv
package l2fl_pkg;
   localparam int VID_W  = 12;
   localparam int FID_W  = 4;
   localparam int PORT_W = 4;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 3;
   localparam int MAIN_PORTS = 8;
   localparam int EXT_PORTS  = 3;
   localparam int MAX_PORTS  = MAIN_PORTS + EXT_PORTS;

   localparam logic [ADDR_W-1:0] A_PORT = 3'd0;
   localparam logic [ADDR_W-1:0] A_EXT  = 3'd1;
   localparam logic [ADDR_W-1:0] A_SEL  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CFG  = 3'd3;
   localparam logic [ADDR_W-1:0] A_ALL  = 3'd4;

   typedef enum logic [1:0] {
      MODE_PORT     = 2'd0,
      MODE_PORT_VID = 2'd1,
      MODE_PORT_FID = 2'd2,
      MODE_RSVD     = 2'd3
   } flush_mode_e;

   typedef struct packed {
      logic              valid;
      logic              mcast;
      logic              stat;
      logic [PORT_W-1:0] port;
      logic [VID_W-1:0]  vid;
      logic [FID_W-1:0]  fid;
   } l2_entry_t;
endpackage

// File: rtl/l2fl_regs.sv
module l2fl_regs
   import l2fl_pkg::*;
#(
   parameter int NUM_PORTS = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_PORTS-1:0] done_mask,
   input  logic                 full_done,
   output logic [NUM_PORTS-1:0] busy,
   output logic                 full_busy,
   output logic [VID_W-1:0]     sel_vid,
   output logic [FID_W-1:0]     sel_fid,
   output flush_mode_e          cfg_mode,
   output logic                 cfg_both
);
   logic                 wr_port, wr_ext, wr_sel, wr_cfg, wr_all;
   logic [NUM_PORTS-1:0] trig;
   logic [MAIN_PORTS-1:0] busy_lo;
   logic [EXT_PORTS-1:0]  busy_hi;

   assign wr_port = bus_we && (bus_addr == A_PORT);
   assign wr_ext  = bus_we && (bus_addr == A_EXT);
   assign wr_sel  = bus_we && (bus_addr == A_SEL);
   assign wr_cfg  = bus_we && (bus_addr == A_CFG);
   assign wr_all  = bus_we && (bus_addr == A_ALL);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_trig
      if (p < MAIN_PORTS) begin : g_main
         assign trig[p] = wr_port && bus_wdata[p];
      end else begin : g_ext
         assign trig[p] = wr_ext && bus_wdata[p-MAIN_PORTS];
      end
   end

   for (genvar i = 0; i < MAIN_PORTS; i++) begin : g_lo
      if (i < NUM_PORTS) begin : g_on
         assign busy_lo[i] = busy[i];
      end else begin : g_off
         assign busy_lo[i] = 1'b0;
      end
   end

   for (genvar i = 0; i < EXT_PORTS; i++) begin : g_hi
      if (i + MAIN_PORTS < NUM_PORTS) begin : g_on
         assign busy_hi[i] = busy[i+MAIN_PORTS];
      end else begin : g_off
         assign busy_hi[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= '0;
         full_busy <= 1'b0;
         sel_vid   <= '0;
         sel_fid   <= '0;
         cfg_mode  <= MODE_PORT;
         cfg_both  <= 1'b0;
      end else begin
         busy <= (busy & ~done_mask) | trig;
         if (wr_all && bus_wdata[0]) begin
            full_busy <= 1'b1;
         end else if (full_done) begin
            full_busy <= 1'b0;
         end
         if (wr_sel) begin
            sel_vid <= bus_wdata[VID_W-1:0];
            sel_fid <= bus_wdata[VID_W +: FID_W];
         end
         if (wr_cfg) begin
            cfg_mode <= flush_mode_e'(bus_wdata[1:0]);
            cfg_both <= bus_wdata[2];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_PORT:  bus_rdata = {busy_lo, {MAIN_PORTS{1'b0}}};
         A_EXT:   bus_rdata = {{(DATA_W-2*EXT_PORTS){1'b0}}, busy_hi, {EXT_PORTS{1'b0}}};
         A_SEL:   bus_rdata = {sel_fid, sel_vid};
         A_CFG:   bus_rdata = {{(DATA_W-3){1'b0}}, cfg_both, cfg_mode};
         A_ALL:   bus_rdata = {{(DATA_W-1){1'b0}}, full_busy};
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/l2fl_pick.sv
module l2fl_pick
   import l2fl_pkg::*;
#(
   parameter int NUM_PORTS = 11
) (
   input  logic [NUM_PORTS-1:0] req,
   output logic [PORT_W-1:0]    first
);
   always_comb begin
      first = '0;
      for (int i = NUM_PORTS - 1; i >= 0; i--) begin
         if (req[i]) first = PORT_W'(i);
      end
   end
endmodule

// File: rtl/l2fl_match.sv
module l2fl_match
   import l2fl_pkg::*;
(
   input  l2_entry_t          entry,
   input  logic [PORT_W-1:0]  port,
   input  flush_mode_e        mode,
   input  logic               both,
   input  logic [VID_W-1:0]   vid,
   input  logic [FID_W-1:0]   fid,
   output logic               hit
);
   logic base_ok, key_ok;

   assign base_ok = entry.valid && !entry.mcast && (entry.port == port)
                    && (both || !entry.stat);

   always_comb begin
      case (mode)
         MODE_PORT_VID: key_ok = (entry.vid == vid);
         MODE_PORT_FID: key_ok = (entry.fid == fid);
         default:       key_ok = 1'b1;
      endcase
   end

   assign hit = base_ok && key_ok;
endmodule

// File: rtl/l2fl_table.sv
module l2fl_table
   import l2fl_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  l2_entry_t        wr_entry,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [IDX_W-1:0] scan_idx,
   output l2_entry_t        scan_entry,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid
);
   l2_entry_t mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (clr_en) mem[clr_idx].valid <= 1'b0;
         if (wr_en)  mem[wr_idx] <= wr_entry;
      end
   end

   assign scan_entry = mem[scan_idx];
   assign rd_valid   = mem[rd_idx].valid;
endmodule

// File: rtl/l2_flush_engine.sv
module l2_flush_engine
   import l2fl_pkg::*;
#(
   parameter int NUM_PORTS = 11,
   parameter int DEPTH     = 32,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [2:0]           bus_addr,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   input  logic                 tbl_we,
   input  logic [IDX_W-1:0]     tbl_widx,
   input  logic                 tbl_wvalid,
   input  logic                 tbl_wmcast,
   input  logic                 tbl_wstatic,
   input  logic [3:0]           tbl_wport,
   input  logic [11:0]          tbl_wvid,
   input  logic [3:0]           tbl_wfid,
   input  logic [IDX_W-1:0]     tbl_ridx,
   output logic                 tbl_rvalid
);
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("NUM_PORTS must lie in 1..%0d", MAX_PORTS);
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   typedef enum logic {ST_IDLE, ST_SCAN} state_e;

   state_e               state;
   logic                 scan_full;
   logic [PORT_W-1:0]    cur_port;
   logic [IDX_W-1:0]     idx;
   flush_mode_e          mode_l;
   logic                 both_l;
   logic [VID_W-1:0]     vid_l;
   logic [FID_W-1:0]     fid_l;

   logic [NUM_PORTS-1:0] busy, done_mask;
   logic                 full_busy, full_done;
   logic [VID_W-1:0]     sel_vid;
   logic [FID_W-1:0]     sel_fid;
   flush_mode_e          cfg_mode;
   logic                 cfg_both;
   logic [PORT_W-1:0]    next_port;
   l2_entry_t            scan_entry, wr_entry;
   logic                 hit, scan_act, scan_last, clr_en;

   l2fl_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .done_mask(done_mask), .full_done(full_done),
      .busy(busy), .full_busy(full_busy),
      .sel_vid(sel_vid), .sel_fid(sel_fid),
      .cfg_mode(cfg_mode), .cfg_both(cfg_both)
   );

   l2fl_pick #(.NUM_PORTS(NUM_PORTS)) u_pick (
      .req(busy), .first(next_port)
   );

   l2fl_match u_match (
      .entry(scan_entry), .port(cur_port), .mode(mode_l), .both(both_l),
      .vid(vid_l), .fid(fid_l), .hit(hit)
   );

   assign wr_entry = '{valid: tbl_wvalid, mcast: tbl_wmcast, stat: tbl_wstatic,
                       port: tbl_wport, vid: tbl_wvid, fid: tbl_wfid};

   l2fl_table #(.DEPTH(DEPTH)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_entry(wr_entry),
      .clr_en(clr_en), .clr_idx(idx),
      .scan_idx(idx), .scan_entry(scan_entry),
      .rd_idx(tbl_ridx), .rd_valid(tbl_rvalid)
   );

   assign scan_act  = (state == ST_SCAN);
   assign scan_last = scan_act && (idx == IDX_W'(DEPTH - 1));
   assign clr_en    = scan_act && (scan_full ? scan_entry.valid : hit);
   assign full_done = scan_last && scan_full;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_done
      assign done_mask[p] = scan_last && !scan_full && (cur_port == PORT_W'(p));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         scan_full <= 1'b0;
         cur_port  <= '0;
         idx       <= '0;
         mode_l    <= MODE_PORT;
         both_l    <= 1'b0;
         vid_l     <= '0;
         fid_l     <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               idx <= '0;
               if (full_busy) begin
                  state     <= ST_SCAN;
                  scan_full <= 1'b1;
               end else if (|busy) begin
                  state     <= ST_SCAN;
                  scan_full <= 1'b0;
                  cur_port  <= next_port;
                  mode_l    <= cfg_mode;
                  both_l    <= cfg_both;
                  vid_l     <= sel_vid;
                  fid_l     <= sel_fid;
               end
            end
            default: begin
               if (scan_last) begin
                  state <= ST_IDLE;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/l2fl_chk.sv
module l2fl_chk
   import l2fl_pkg::*;
#(
   parameter int NUM_PORTS = 11
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_we,
   input logic [2:0]           bus_addr,
   input logic [15:0]          bus_wdata,
   input logic [15:0]          bus_rdata,
   input logic [NUM_PORTS-1:0] busy,
   input logic                 full_busy,
   input logic                 scan_act,
   input logic                 scan_full,
   input logic [PORT_W-1:0]    cur_port,
   input logic                 clr_en,
   input logic                 both_l,
   input l2_entry_t            scan_entry
);
   AST_PORT0_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == A_PORT && bus_wdata[0] |=> busy[0]); // R2

   AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_PORT |-> bus_rdata[7:0] == 8'h00); // R2

   AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == A_ALL && bus_wdata[0] |=> full_busy); // R10

   AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      scan_act && scan_full |-> full_busy); // R10

   AST_STATIC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && !scan_full && !both_l |-> !scan_entry.stat); // R8

   AST_OWN_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && !scan_full |-> !scan_entry.mcast && scan_entry.port == cur_port); // R4

   AST_SCAN_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      scan_act && !scan_full |-> busy[cur_port]); // R9
endmodule

bind l2_flush_engine l2fl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .busy(busy), .full_busy(full_busy),
   .scan_act(scan_act), .scan_full(scan_full), .cur_port(cur_port),
   .clr_en(clr_en), .both_l(both_l), .scan_entry(scan_entry)
);

// File: tb/l2_flush_engine_tb.sv
module l2_flush_engine_tb;
   localparam int DEPTH = 32;
   localparam int IDX_W = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic tbl_we = 1'b0;
   logic [IDX_W-1:0] tbl_widx = '0;
   logic tbl_wvalid = 1'b0, tbl_wmcast = 1'b0, tbl_wstatic = 1'b0;
   logic [3:0] tbl_wport = '0;
   logic [11:0] tbl_wvid = '0;
   logic [3:0] tbl_wfid = '0;
   logic [IDX_W-1:0] tbl_ridx = '0;
   logic tbl_rvalid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   l2_flush_engine #(.NUM_PORTS(11), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wvalid(tbl_wvalid),
      .tbl_wmcast(tbl_wmcast), .tbl_wstatic(tbl_wstatic), .tbl_wport(tbl_wport),
      .tbl_wvid(tbl_wvid), .tbl_wfid(tbl_wfid),
      .tbl_ridx(tbl_ridx), .tbl_rvalid(tbl_rvalid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic load(input int i, input bit v, input bit m, input bit s,
                       input int port, input int vid, input int fid);
      @(negedge clk);
      tbl_we = 1'b1; tbl_widx = IDX_W'(i); tbl_wvalid = v; tbl_wmcast = m;
      tbl_wstatic = s; tbl_wport = 4'(port); tbl_wvid = 12'(vid); tbl_wfid = 4'(fid);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic valid_of(input int i, output bit v);
      tbl_ridx = IDX_W'(i);
      #1;
      v = tbl_rvalid;
   endtask

   task automatic wait_idle();
      logic [15:0] a, b, c;
      for (int n = 0; n < 2000; n++) begin
         bus_rd(3'd0, a); bus_rd(3'd1, b); bus_rd(3'd4, c);
         if (a == 0 && b == 0 && c == 0) return;
         @(negedge clk);
      end
      check(1'b0, "wait_idle timeout", 1, 0);
   endtask

   task automatic wipe();
      bus_wr(3'd4, 16'h0001);
      wait_idle();
   endtask

   task automatic expect_valid(input int i, input bit exp, input string req);
      bit v;
      valid_of(i, v);
      check(v == exp, req, int'(v), int'(exp));
   endtask

   task automatic t_reset();
      logic [15:0] d;
      for (int a = 0; a < 5; a++) begin
         bus_rd(3'(a), d);
         check(d == 16'h0, "R1 register reset", d, 0);
      end
      expect_valid(0, 1'b0, "R1 table empty");
   endtask

   task automatic t_latency();
      logic [15:0] d;
      bus_wr(3'd3, 16'h0000);
      load(3, 1, 0, 0, 2, 5, 0);
      bus_wr(3'd0, 16'h0000);
      bus_rd(3'd0, d);
      check(d == 16'h0, "R11 zero write starts nothing", d, 0);
      bus_wr(3'd0, 16'h0004);
      bus_rd(3'd0, d);
      check(d == 16'h0400, "R2 busy set, trigger reads zero", d, 16'h0400);
      repeat (DEPTH) @(negedge clk);
      bus_rd(3'd0, d);
      check(d == 16'h0400, "R11 busy before end", d, 16'h0400);
      @(negedge clk);
      bus_rd(3'd0, d);
      check(d == 16'h0, "R11 busy clear at DEPTH+1", d, 0);
      expect_valid(3, 1'b0, "R2 entry removed");
   endtask

   task automatic t_ext();
      logic [15:0] d;
      load(0, 1, 0, 0, 9, 1, 0);
      load(1, 1, 0, 0, 1, 1, 0);
      bus_wr(3'd1, 16'h0002);
      bus_rd(3'd1, d);
      check(d == 16'h0010, "R3 ext busy bit", d, 16'h0010);
      wait_idle();
      expect_valid(0, 1'b0, "R3 port 9 removed");
      expect_valid(1, 1'b1, "R3 port 1 kept");
   endtask

   task automatic t_mode_port();
      bus_wr(3'd3, 16'h0000);
      load(4, 1, 0, 0, 5, 7, 1);
      load(5, 1, 1, 0, 5, 7, 1);
      load(6, 1, 0, 0, 6, 7, 1);
      load(7, 1, 0, 1, 5, 7, 1);
      bus_wr(3'd0, 16'h0020);
      wait_idle();
      expect_valid(4, 1'b0, "R4 own unicast removed");
      expect_valid(5, 1'b1, "R4 multicast kept");
      expect_valid(6, 1'b1, "R4 other port kept");
      expect_valid(7, 1'b1, "R8 static kept when dynamic-only");
   endtask

   task automatic t_vid_fid();
      logic [15:0] d;
      bus_wr(3'd2, 16'h9123);
      bus_rd(3'd2, d);
      check(d == 16'h9123, "R5 selection readback", d, 16'h9123);
      bus_wr(3'd3, 16'h0001);
      load(8, 1, 0, 0, 3, 12'h123, 4);
      load(9, 1, 0, 0, 3, 12'h124, 9);
      bus_wr(3'd0, 16'h0008);
      wait_idle();
      expect_valid(8, 1'b0, "R5 vid match removed");
      expect_valid(9, 1'b1, "R5 vid mismatch kept");
      bus_wr(3'd3, 16'h0002);
      load(10, 1, 0, 0, 3, 12'h123, 4);
      bus_wr(3'd0, 16'h0008);
      wait_idle();
      expect_valid(9, 1'b0, "R6 fid match removed");
      expect_valid(10, 1'b1, "R6 fid mismatch kept");
   endtask

   task automatic t_mode3();
      bus_wr(3'd3, 16'h0003);
      load(11, 1, 0, 0, 4, 1, 1);
      load(12, 1, 0, 0, 4, 2, 2);
      bus_wr(3'd0, 16'h0010);
      wait_idle();
      expect_valid(11, 1'b0, "R7 mode 3 as port-only a");
      expect_valid(12, 1'b0, "R7 mode 3 as port-only b");
   endtask

   task automatic t_both();
      bus_wr(3'd3, 16'h0004);
      load(13, 1, 0, 1, 5, 0, 0);
      load(14, 1, 1, 1, 5, 0, 0);
      bus_wr(3'd0, 16'h0020);
      wait_idle();
      expect_valid(7, 1'b0, "R8 static removed with both");
      expect_valid(13, 1'b0, "R8 static removed with both b");
      expect_valid(14, 1'b1, "R8 multicast still kept");
   endtask

   task automatic t_order();
      logic [15:0] d;
      bus_wr(3'd3, 16'h0000);
      bus_wr(3'd0, 16'h0042);
      bus_rd(3'd0, d);
      check(d == 16'h4200, "R9 both busy", d, 16'h4200);
      repeat (DEPTH + 1) @(negedge clk);
      bus_rd(3'd0, d);
      check(d == 16'h4000, "R9 lower port done first", d, 16'h4000);
      repeat (DEPTH) @(negedge clk);
      bus_rd(3'd0, d);
      check(d == 16'h4000, "R9 higher port still busy", d, 16'h4000);
      @(negedge clk);
      bus_rd(3'd0, d);
      check(d == 16'h0, "R9 higher port done", d, 0);
   endtask

   task automatic t_full();
      logic [15:0] d;
      load(15, 1, 0, 1, 2, 0, 0);
      load(16, 1, 1, 0, 2, 0, 0);
      load(17, 1, 0, 0, 7, 0, 0);
      bus_wr(3'd0, 16'h0001);
      bus_wr(3'd0, 16'h0080);
      bus_wr(3'd4, 16'h0001);
      bus_rd(3'd4, d);
      check(d == 16'h0001, "R10 whole-table bit reads 1", d, 1);
      for (int n = 0; n < 500; n++) begin
         bus_rd(3'd4, d);
         if (d == 0) break;
         @(negedge clk);
      end
      check(d == 16'h0, "R10 whole-table bit self-clears", d, 0);
      bus_rd(3'd0, d);
      check(d == 16'h8000, "R10 whole-table before pending port", d, 16'h8000);
      wait_idle();
      expect_valid(15, 1'b0, "R10 static removed");
      expect_valid(16, 1'b0, "R10 multicast removed");
      expect_valid(17, 1'b0, "R10 dynamic removed");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_ext();
      t_mode_port();
      t_vid_fid();
      t_mode3();
      t_both();
      t_order();
      t_full();
      wipe();
      expect_valid(14, 1'b0, "R10 wipe");
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x1 expected=0x0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule